// File: doc/BRIEF.md
# Chip-Select-Edge Memory Access Front End

This block sits between the external pins of a 64K x 16 word memory and the internal storage port. All pins are sampled by one fast system clock. The chip-select pin passes through a two-flop synchronizer, and only the synchronized level is used for edge detection. On an accepted rising edge, the block captures the address, the write-enable level, the input data and the half-select inhibit state. It then holds the chip-select high time against a qualification threshold. A read needs a short minimum high time, which rejects glitches. A write needs a longer one. Once the pulse qualifies, the block issues exactly one request to the storage port.

Each accepted edge opens a lockout window whose length depends on whether the access is a read or a write. Another rising edge inside that window is discarded, and the block marks it with a one-cycle flag. Writes are blocked per address half by two active-low inhibit inputs. The last word read from storage is held on the data output. The output-drive enable is formed from the live output-enable pin, the synchronized chip select and the kind of the last qualified access.

The request interface is valid/ready. Once `req_valid` is raised, it and every request field stay constant until the cycle in which `req_ready` is high. The handshake completes in that cycle. Read data returns on `rsp_valid`, which has no back-pressure. Each `rsp_valid` cycle loads the held word. A storage port that stalls `req_ready` also stretches the lockout: edges that arrive while a request is still waiting are dropped.

Top module: `cse_access_front`

## Requirements
- R1: After reset, `req_valid`, `rdata_drive` and `edge_dropped` are all 0.
- R2: A qualified access issues one request. It carries the address and write data that were present when the synchronized edge was accepted, and `req_write` equals the write-enable level seen then. Pin changes after that point have no effect on the request.
- R3: A read pulse whose chip select is sampled high for fewer than GLITCH_CYC consecutive cycles (default 3) issues no request. A pulse of exactly GLITCH_CYC cycles issues one.
- R4: A write pulse sampled high for fewer than WRITE_PW_CYC cycles (default 5) issues no request and leaves storage unchanged. This holds even when the pulse is at least GLITCH_CYC cycles long. A pulse of exactly WRITE_PW_CYC cycles issues the write.
- R5: `wr_block_n[0]` low blocks writes to addresses with bit 15 = 0, and `wr_block_n[1]` low blocks writes with bit 15 = 1. A blocked write issues no request.
- R6: Every `rsp_valid` cycle loads `rsp_data` into the held word on `rdata_out`.
- R7: `rdata_drive` is 1 only when `out_en` is 1, the synchronized chip select is 1, and the last qualified access was a read. `out_en` acts in the same cycle without being latched. After a qualified write, including a blocked one, `rdata_drive` is 0.
- R8: If `out_en` stays high across a new read edge, `rdata_out` keeps presenting the previous word until the new read data returns.
- R9: A rising edge that arrives fewer than READ_CYC (default 11) cycles after an accepted read edge, or fewer than WRITE_CYC (default 14) cycles after an accepted write edge, is dropped and `edge_dropped` pulses for exactly one cycle. An edge at or beyond the limit is accepted.
- R10: While `req_valid` is 1 and `req_ready` is 0, the request fields hold steady. An edge that arrives while a request is still waiting is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Asynchronous chip select; its rising edge starts an access |
| wr_en | input | 1 | Access direction, 1 = write, captured at the edge |
| out_en | input | 1 | Output enable, not latched |
| addr | input | 16 | Word address; bit 15 selects the half |
| wdata | input | 16 | Write data, captured at the edge |
| wr_block_n | input | 2 | Active-low write inhibit per address half |
| rdata_out | output | 16 | Held word from the last read |
| rdata_drive | output | 1 | Tri-state enable for the data pads |
| edge_dropped | output | 1 | One-cycle pulse for an edge rejected by lockout |
| req_valid | output | 1 | Storage request valid |
| req_ready | input | 1 | Storage request ready |
| req_write | output | 1 | Request is a write |
| req_addr | output | 16 | Request address |
| req_wdata | output | 16 | Request write data |
| rsp_valid | input | 1 | Read data valid pulse |
| rsp_data | input | 16 | Read data |

## Verification
A corrupted qualification counter shows up at the request port within one pulse. The pulse-width sweeps change the required high time one cycle at a time, so a threshold that is off by one either drops the last legal width or passes the first illegal one. A wrong lockout counter or state shows up on the second edge of a pair spaced one cycle either side of each limit, as an unexpected drop flag or a missing request. A stale direction flag or held word appears at the data pins within a few cycles of the next read edge, because the bench samples the pins both before and after the read data returns.

// File: rtl/cse_pkg.sv
package cse_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_QUAL,
    ST_ISSUE,
    ST_LOCK
  } acc_state_e;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/cse_edge_sync.sv
module cse_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic rise
);
  logic [STAGES-1:0] shreg;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      prev  <= 1'b0;
    end else begin
      shreg <= {shreg[STAGES-2:0], async_in};
      prev  <= shreg[STAGES-1];
    end
  end

  assign sync_out = shreg[STAGES-1];
  assign rise     = shreg[STAGES-1] & ~prev;
endmodule

// File: rtl/cse_access_fsm.sv
module cse_access_fsm
  import cse_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int GLITCH_CYC   = 3,
  parameter int WRITE_PW_CYC = 5,
  parameter int READ_CYC     = 11,
  parameter int WRITE_CYC    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_sync,
  input  logic              cs_rise,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              we_in,
  input  logic [DATA_W-1:0] din_in,
  input  logic [1:0]        blk_n_in,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              qual_fire,
  output logic              qual_read,
  output logic              edge_dropped
);
  localparam int CNT_MAX = max_of3(READ_CYC, WRITE_CYC, WRITE_PW_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  acc_state_e        state;
  logic [CNT_W-1:0]  cnt, cnt_inc, need, limit;
  logic              cap_we, cap_blk;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              lock_done, accept;

  // cnt holds cycles elapsed since the accepted edge
  assign cnt_inc   = (cnt == CNT_W'(CNT_MAX)) ? cnt : cnt + 1'b1;
  assign need      = cap_we ? CNT_W'(WRITE_PW_CYC - 1) : CNT_W'(GLITCH_CYC - 1);
  assign limit     = cap_we ? CNT_W'(WRITE_CYC) : CNT_W'(READ_CYC);
  assign lock_done = (state == ST_LOCK) && (cnt >= limit);
  assign accept    = cs_rise && ((state == ST_IDLE) || lock_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cap_we   <= 1'b0;
      cap_blk  <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else if (accept) begin
      state    <= ST_QUAL;
      cnt      <= CNT_W'(1);
      cap_we   <= we_in;
      cap_blk  <= we_in && !blk_n_in[addr_in[ADDR_W-1]];
      cap_addr <= addr_in;
      cap_data <= din_in;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_QUAL: begin
          if (!cs_sync) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt_inc;
            if (cnt >= need) state <= cap_blk ? ST_LOCK : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          cnt <= cnt_inc;
          if (req_ready) state <= ST_LOCK;
        end
        ST_LOCK: begin
          if (cnt >= limit) state <= ST_IDLE;
          else              cnt   <= cnt_inc;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign qual_fire    = (state == ST_QUAL) && cs_sync && (cnt >= need);
  assign qual_read    = !cap_we;
  assign edge_dropped = cs_rise && !accept;
  assign req_valid    = (state == ST_ISSUE);
  assign req_write    = cap_we;
  assign req_addr     = cap_addr;
  assign req_wdata    = cap_data;
endmodule

// File: rtl/cse_read_hold.sv
module cse_read_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              qual_fire,
  input  logic              qual_read,
  input  logic              cs_sync,
  input  logic              oe_in,
  output logic [DATA_W-1:0] rdata_out,
  output logic              rdata_drive
);
  logic [DATA_W-1:0] held;
  logic              rd_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= '0;
      rd_mode <= 1'b0;
    end else begin
      if (rsp_valid) held    <= rsp_data;
      if (qual_fire) rd_mode <= qual_read;
    end
  end

  assign rdata_out   = held;
  assign rdata_drive = rd_mode && cs_sync && oe_in;
endmodule

// File: rtl/cse_access_front.sv
module cse_access_front #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int GLITCH_CYC   = 3,
  parameter int WRITE_PW_CYC = 5,
  parameter int READ_CYC     = 11,
  parameter int WRITE_CYC    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel,
  input  logic              wr_en,
  input  logic              out_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        wr_block_n,
  output logic [DATA_W-1:0] rdata_out,
  output logic              rdata_drive,
  output logic              edge_dropped,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data
);
  logic cs_sync, cs_rise, qual_fire, qual_read;

  cse_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (chip_sel),
    .sync_out (cs_sync),
    .rise     (cs_rise)
  );

  cse_access_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC),
    .WRITE_PW_CYC(WRITE_PW_CYC), .READ_CYC(READ_CYC), .WRITE_CYC(WRITE_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_sync      (cs_sync),
    .cs_rise      (cs_rise),
    .addr_in      (addr),
    .we_in        (wr_en),
    .din_in       (wdata),
    .blk_n_in     (wr_block_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .qual_fire    (qual_fire),
    .qual_read    (qual_read),
    .edge_dropped (edge_dropped)
  );

  cse_read_hold #(.DATA_W(DATA_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .qual_fire   (qual_fire),
    .qual_read   (qual_read),
    .cs_sync     (cs_sync),
    .oe_in       (out_en),
    .rdata_out   (rdata_out),
    .rdata_drive (rdata_drive)
  );
endmodule

// File: rtl/cse_access_checker.sv
module cse_access_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_en,
  input logic              cs_sync,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rdata_out,
  input logic              rdata_drive,
  input logic              edge_dropped
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write) &&
                                $stable(req_addr) && $stable(req_wdata));

  p_pads_follow_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_drive |-> out_en);

  p_no_drive_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> !rdata_drive);

  p_word_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> $stable(rdata_out));

  p_drop_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_dropped |=> !edge_dropped);

  p_req_after_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(cs_sync));
endmodule

bind cse_access_front cse_access_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .out_en       (out_en),
  .cs_sync      (cs_sync),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .rdata_out    (rdata_out),
  .rdata_drive  (rdata_drive),
  .edge_dropped (edge_dropped)
);

// File: tb/tb_cse_access_front.sv
module tb_cse_access_front;
  localparam int GL = 3, WP = 5, RC = 11, WC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_sel = 1'b0, wr_en = 1'b0, out_en = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [1:0]  wr_block_n = 2'b11;
  logic [15:0] rdata_out;
  logic        rdata_drive, edge_dropped;
  logic        req_valid, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        stall = 1'b0;
  logic        req_ready;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;
  logic        pend_v = 1'b0;
  logic [15:0] pend_d = '0;

  int n_cmp = 0, n_bad = 0;
  int n_wr = 0, n_rd = 0, n_drop = 0;
  logic        last_write = 1'b0;
  logic [15:0] last_addr = '0, last_wdata = '0;
  logic [15:0] mem [logic [15:0]];
  bit finished = 0;

  always #2 clk = ~clk;
  assign req_ready = !stall;

  cse_access_front dut (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .wr_en(wr_en), .out_en(out_en),
    .addr(addr), .wdata(wdata), .wr_block_n(wr_block_n),
    .rdata_out(rdata_out), .rdata_drive(rdata_drive), .edge_dropped(edge_dropped),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [15:0] model_rd(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 16'hA5C3;
  endfunction

  // storage model: read data returns two edges after the handshake
  always @(posedge clk) begin
    rsp_valid <= pend_v;
    rsp_data  <= pend_d;
    pend_v    <= 1'b0;
    if (rst_n && req_valid && req_ready) begin
      last_write = req_write;
      last_addr  = req_addr;
      last_wdata = req_wdata;
      if (req_write) begin
        mem[req_addr] = req_wdata;
        n_wr++;
      end else begin
        pend_v <= 1'b1;
        pend_d <= model_rd(req_addr);
        n_rd++;
      end
    end
    if (rst_n && edge_dropped) n_drop++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic pulse(input logic w, input logic [15:0] a, input logic [15:0] d,
                       input int width, input int scramble);
    @(negedge clk);
    addr = a; wr_en = w; wdata = d; chip_sel = 1'b1;
    for (int i = 1; i <= width; i++) begin
      @(negedge clk);
      if (i == scramble) begin addr = ~a; wdata = ~d; wr_en = ~w; end
    end
    chip_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic two_edges(input logic w, input int width, input int gap);
    @(negedge clk);
    addr = 16'h0200 + 16'(gap); wdata = 16'h3000 + 16'(gap); wr_en = w; chip_sel = 1'b1;
    repeat (width) @(negedge clk);
    chip_sel = 1'b0;
    repeat (gap - width) @(negedge clk);
    chip_sel = 1'b1;
    repeat (width) @(negedge clk);
    chip_sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    int w0, r0, d0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 req_valid", req_valid, 0);
    check("R1 rdata_drive", rdata_drive, 0);
    check("R1 edge_dropped", edge_dropped, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 capture, pins scrambled after the accepted edge
    w0 = n_wr;
    pulse(1'b1, 16'h1234, 16'hBEEF, 8, 4);
    settle();
    check("R2 write count", n_wr - w0, 1);
    check("R2 write flag", last_write, 1);
    check("R2 address", last_addr, 16'h1234);
    check("R2 data", last_wdata, 16'hBEEF);
    r0 = n_rd;
    pulse(1'b0, 16'h1234, 16'h0000, 8, 4);
    settle();
    check("R2 read count", n_rd - r0, 1);
    check("R2 read flag", last_write, 0);
    check("R6 read word", rdata_out, 16'hBEEF);

    // R3 read glitch sweep
    for (int w = 1; w <= GL; w++) begin
      r0 = n_rd; d0 = n_drop;
      pulse(1'b0, 16'h0010 + 16'(w), 16'h0, w, 0);
      settle();
      check("R3 read pulse", n_rd - r0, (w >= GL) ? 1 : 0);
      check("R3 no drop", n_drop - d0, 0);
    end

    // R4 write width sweep, storage checked by read back
    for (int w = GL; w <= WP; w++) begin
      logic [15:0] a;
      a = 16'h0100 + 16'(w);
      w0 = n_wr;
      pulse(1'b1, a, 16'h5A00 + 16'(w), w, 0);
      settle();
      check("R4 write pulse", n_wr - w0, (w >= WP) ? 1 : 0);
      pulse(1'b0, a, 16'h0, GL, 0);
      settle();
      check("R4 stored word", rdata_out, (w >= WP) ? (16'h5A00 + 16'(w)) : (a ^ 16'hA5C3));
    end

    // R5 inhibit sweep over both halves and all inhibit codes
    for (int blk = 0; blk < 4; blk++) begin
      for (int h = 0; h < 2; h++) begin
        logic [15:0] a;
        a = {h[0], 15'h0400} + 16'(blk);
        wr_block_n = blk[1:0];
        w0 = n_wr;
        pulse(1'b1, a, 16'hC000 + 16'(blk * 2 + h), WP, 0);
        settle();
        check("R5 inhibit", n_wr - w0, blk[h] ? 1 : 0);
        wr_block_n = 2'b11;
        pulse(1'b0, a, 16'h0, GL, 0);
        settle();
        check("R5 stored word", rdata_out, blk[h] ? (16'hC000 + 16'(blk * 2 + h)) : (a ^ 16'hA5C3));
      end
    end

    // R7 output drive gating with a long read pulse
    out_en = 1'b1;
    @(negedge clk);
    addr = 16'h0777; wr_en = 1'b0; chip_sel = 1'b1;
    repeat (10) @(negedge clk);
    check("R7 drive on read", rdata_drive, 1);
    check("R6 word on read", rdata_out, 16'h0777 ^ 16'hA5C3);
    out_en = 1'b0; #1;
    check("R7 out_en low", rdata_drive, 0);
    out_en = 1'b1; #1;
    check("R7 out_en high again", rdata_drive, 1);
    @(negedge clk);
    chip_sel = 1'b0;
    settle();
    check("R7 chip select low", rdata_drive, 0);

    // R8 previous word held across a new read edge
    @(negedge clk);
    addr = 16'h1234; chip_sel = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 old word driven", rdata_drive, 1);
    check("R8 old word", rdata_out, 16'h0777 ^ 16'hA5C3);
    repeat (7) @(negedge clk);
    check("R8 new word", rdata_out, 16'hBEEF);
    repeat (2) @(negedge clk);
    chip_sel = 1'b0;
    settle();

    // R7 write and inhibited write leave the pads undriven
    @(negedge clk);
    addr = 16'h0055; wdata = 16'h1111; wr_en = 1'b1; chip_sel = 1'b1;
    repeat (9) @(negedge clk);
    check("R7 write undriven", rdata_drive, 0);
    chip_sel = 1'b0;
    settle();
    pulse(1'b0, 16'h1234, 16'h0, 12, 0);
    settle();
    wr_block_n = 2'b10;
    @(negedge clk);
    addr = 16'h0056; wdata = 16'h2222; wr_en = 1'b1; chip_sel = 1'b1;
    repeat (9) @(negedge clk);
    check("R7 inhibited undriven", rdata_drive, 0);
    chip_sel = 1'b0;
    wr_block_n = 2'b11;
    settle();
    out_en = 1'b0;

    // R9 lockout boundaries for reads and writes
    for (int k = RC - 2; k <= RC + 1; k++) begin
      r0 = n_rd; d0 = n_drop;
      two_edges(1'b0, GL, k);
      settle();
      check("R9 read drop", n_drop - d0, (k < RC) ? 1 : 0);
      check("R9 read count", n_rd - r0, (k < RC) ? 1 : 2);
    end
    for (int k = WC - 2; k <= WC + 1; k++) begin
      w0 = n_wr; d0 = n_drop;
      two_edges(1'b1, WP, k);
      settle();
      check("R9 write drop", n_drop - d0, (k < WC) ? 1 : 0);
      check("R9 write count", n_wr - w0, (k < WC) ? 1 : 2);
    end

    // R10 back-pressure holds the request and drops edges meanwhile
    stall = 1'b1;
    r0 = n_rd; d0 = n_drop;
    pulse(1'b0, 16'h0ABC, 16'h0, GL, 0);
    repeat (16) @(negedge clk);
    check("R10 valid held", req_valid, 1);
    check("R10 address held", req_addr, 16'h0ABC);
    check("R10 no handshake", n_rd - r0, 0);
    pulse(1'b0, 16'h0DEF, 16'h0, GL, 0);
    repeat (3) @(negedge clk);
    check("R10 drop while waiting", n_drop - d0, 1);
    check("R10 address kept", req_addr, 16'h0ABC);
    stall = 1'b0;
    settle();
    check("R10 one handshake", n_rd - r0, 1);
    check("R10 read word", rdata_out, 16'h0ABC ^ 16'hA5C3);

    finish_run();
  end
endmodule